// File: doc/BRIEF.md
# PHY Event Interrupt Aggregator

This block collects six PHY status events and folds them into one host interrupt line. The six events are link change, jabber, remote fault, negotiation done, false-carrier counter at half scale and receive-error counter at half scale. Each event is edge detected and can be masked one by one. The block has a master enable. A sticky pending flag drives the interrupt output. Software reads the pending flag, and that read also clears it.

The host reaches the block through a plain management port. The port has a 2-bit address, a one-cycle read strobe, a one-cycle write strobe and 16-bit write data. Read data is combinational from the current register state during the strobe cycle. Three registers are visible:
- A control register at address 0.
- A status/mask register at address 1.
- A quick-status view at address 2.

A test bit in the control register makes every management read raise the interrupt. This happens whether or not the master enable is set, so software can exercise its interrupt path without a real event. None of the pins is a data stream, so there is no valid/ready handshake and no back-pressure. Every strobe is accepted in the cycle it is high.

Top module: `phyirq_agg`

## Requirements
- R1: After reset the control and status/mask registers read 0000h, the quick view at address 2 reads 0000h, and `irq_o` is low.
- R2: The control register (address 0) keeps only bit 1 (event enable) and bit 0 (test) from a write; bits 15:2 always read 0.
- R3: In the status/mask register (address 1), bits 14:9 are read-write mask bits. Bits 8:0 always read 0. Bit 15 is the pending flag, and writes to it are ignored.
- R4: Event input `evt_i[k]` is governed by mask bit 9+k: k=5 link change, k=4 jabber, k=3 remote fault, k=2 negotiation done, k=1 false-carrier half-full, k=0 receive-error half-full. An unmasked event does not pass through another event's mask.
- R5: An event whose mask bit is 1 never sets the pending flag.
- R6: With the enable bit at 0, no event sets the pending flag.
- R7: The pending flag sets on the clock edge that first samples a 0-to-1 change of an enabled, unmasked event. An event held high does not set it again after it is cleared.
- R8: `irq_o` is high exactly while the pending flag is set. It changes on the same clock edge as the flag.
- R9: A read of address 1 returns the pending flag in bit 15 during the strobe cycle. The flag is clear after that clock edge unless R10 or R11 sets it again.
- R10: A qualifying event edge in the same cycle as a clearing read leaves the pending flag set.
- R11: With the test bit at 1, the edge that ends any management read sets the pending flag, whether or not the enable bit is set.
- R12: Address 2 shows the pending flag at bit 7 with all other bits 0. Reading it does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Event levels from the PHY detectors |
| mgmt_addr | input | 2 | Register select: 0 control, 1 status/mask, 2 quick view |
| mgmt_rd | input | 1 | One-cycle read strobe |
| mgmt_wr | input | 1 | One-cycle write strobe |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data for `mgmt_addr`, combinational |
| irq_o | output | 1 | Interrupt to the host, registered |

## Verification
The assertions assume that `evt_i` is synchronous to `clk`. They also assume that a read and a write are never strobed in the same cycle. The stimulus drives every input on the falling edge and never raises both strobes together. Events are raised and dropped in separate cycles so that each rising edge is distinct. One case deliberately places an event edge inside the strobe cycle of a clearing read.

// File: rtl/phyirq_pkg.sv
package phyirq_pkg;
  localparam int NUM_EVT   = 6;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 2;
  localparam int MASK_LSB  = 9;
  localparam int PEND_BIT  = 15;
  localparam int QUICK_BIT = 7;
  localparam int EN_BIT    = 1;
  localparam int TEST_BIT  = 0;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_STAT  = 2'd1,
    ADDR_QUICK = 2'd2,
    ADDR_NONE  = 2'd3
  } addr_e;
endpackage

// File: rtl/phyirq_edge.sv
module phyirq_edge #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[i] <= 1'b0;
      else        lvl_q[i] <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~lvl_q[i];

    // R7: a rising edge lasts one cycle only
    a_r7_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/phyirq_regs.sv
module phyirq_regs
  import phyirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pend_i,
  output logic              en_o,
  output logic              test_o,
  output logic [NUM_EVT-1:0] mask_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              en_q, test_q;
  logic [NUM_EVT-1:0] mask_q;
  logic [DATA_W-1:0] ctrl_v, stat_v, quick_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      test_q <= 1'b0;
      mask_q <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_CTRL) begin
        en_q   <= wdata_i[EN_BIT];
        test_q <= wdata_i[TEST_BIT];
      end else if (addr_i == ADDR_STAT) begin
        mask_q <= wdata_i[MASK_LSB +: NUM_EVT];
      end
    end
  end

  always_comb begin
    ctrl_v  = '0;
    ctrl_v[EN_BIT]   = en_q;
    ctrl_v[TEST_BIT] = test_q;
    stat_v  = '0;
    stat_v[MASK_LSB +: NUM_EVT] = mask_q;
    stat_v[PEND_BIT] = pend_i;
    quick_v = '0;
    quick_v[QUICK_BIT] = pend_i;
    case (addr_i)
      ADDR_CTRL:  rdata_o = ctrl_v;
      ADDR_STAT:  rdata_o = stat_v;
      ADDR_QUICK: rdata_o = quick_v;
      default:    rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign test_o = test_q;
  assign mask_o = mask_q;

  a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == ADDR_STAT) |=> $stable(mask_q));
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == ADDR_CTRL) |=> ($stable(en_q) && $stable(test_q)));
endmodule

// File: rtl/phyirq_pend.sv
module phyirq_pend
  import phyirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] rise_i,
  input  logic [NUM_EVT-1:0] mask_i,
  input  logic               en_i,
  input  logic               test_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               pend_o
);
  logic pend_q, evt_hit, test_hit, clr;

  assign evt_hit  = en_i & |(rise_i & ~mask_i);
  assign test_hit = rd_i & test_i;
  assign clr      = rd_i & (addr_i == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pend_q <= 1'b0;
    else if (evt_hit || test_hit) pend_q <= 1'b1;
    else if (clr)                 pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == ADDR_STAT && en_i && |(rise_i & ~mask_i)) |=> pend_q);
  a_r9_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == ADDR_STAT && !test_i && !(en_i && |(rise_i & ~mask_i)))
      |=> !pend_q);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !en_i && !(rd_i && test_i)) |=> !pend_q);
  a_r11_test_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && test_i) |=> pend_q);
endmodule

// File: rtl/phyirq_agg.sv
module phyirq_agg
  import phyirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [ADDR_W-1:0]  mgmt_addr,
  input  logic               mgmt_rd,
  input  logic               mgmt_wr,
  input  logic [DATA_W-1:0]  mgmt_wdata,
  output logic [DATA_W-1:0]  mgmt_rdata,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] rise, mask;
  logic en, test, pend;

  phyirq_edge #(.N(NUM_EVT)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(evt_i), .rise_o(rise));

  phyirq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(mgmt_addr), .wr_i(mgmt_wr),
    .wdata_i(mgmt_wdata), .pend_i(pend), .en_o(en), .test_o(test),
    .mask_o(mask), .rdata_o(mgmt_rdata));

  phyirq_pend u_pend (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .mask_i(mask), .en_i(en),
    .test_i(test), .rd_i(mgmt_rd), .addr_i(mgmt_addr), .pend_o(pend));

  assign irq_o = pend;

  // R5: a fully masked event set never creates a new interrupt
  a_r5_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && (&mask) && !(mgmt_rd && test)) |=> !irq_o);
endmodule

// File: tb/phyirq_agg_bench.sv
module phyirq_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  evt = '0;
  logic [1:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  phyirq_agg u_phyirq_agg (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .mgmt_addr(addr), .mgmt_rd(rd),
    .mgmt_wr(wr), .mgmt_wdata(wdata), .mgmt_rdata(rdata), .irq_o(irq));

  // monitor: compares read data with the scoreboard queue
  always @(negedge clk) begin
    #1;
    if (rd) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic rd_reg(input logic [1:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    rd = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd_with_evt(input logic [1:0] a, input logic [5:0] ev,
                             input logic [15:0] e, input string t);
    @(negedge clk);
    rd = 1'b1; addr = a; evt = ev;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic set_evt(input logic [5:0] ev);
    @(negedge clk);
    evt = ev;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    #1;
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd_reg(2'd0, 16'h0000, "R1 ctrl");
    rd_reg(2'd1, 16'h0000, "R1 stat");
    rd_reg(2'd2, 16'h0000, "R1 quick");

    // R2 control write; test bit on makes reads set pending (R11)
    wr_reg(2'd0, 16'hFFFF);
    rd_reg(2'd0, 16'h0003, "R2 ctrl reserved");
    chk_irq(1'b1, "R11 test read");
    rd_reg(2'd1, 16'h8000, "R11 pending from test");
    wr_reg(2'd0, 16'h0002);
    rd_reg(2'd1, 16'h8000, "R11 re-set by test read");
    rd_reg(2'd1, 16'h0000, "R9 cleared");
    chk_irq(1'b0, "R8 irq low after clear");

    // R3 mask bits only
    wr_reg(2'd1, 16'hFFFF);
    rd_reg(2'd1, 16'h7E00, "R3 mask bits");

    // R5 all masked
    set_evt(6'h3F);
    chk_irq(1'b0, "R5 masked");
    set_evt(6'h00);
    rd_reg(2'd1, 16'h7E00, "R5 no pending");

    // R4 per-event mapping, R7 level hold, R9 clear
    for (int k = 0; k < 6; k++) begin
      logic [15:0] m;
      m = 16'h7E00 & ~(16'h0001 << (9 + k));
      wr_reg(2'd1, m);
      set_evt(6'h3F & ~(6'h01 << k));
      chk_irq(1'b0, "R4 other events masked");
      set_evt(6'h00);
      set_evt(6'h01 << k);
      chk_irq(1'b1, "R4 unmasked event");
      rd_reg(2'd1, m | 16'h8000, "R9 pending visible");
      rd_reg(2'd1, m, "R7 held level no re-set");
      set_evt(6'h00);
    end

    // R6 enable off
    wr_reg(2'd1, 16'h0000);
    wr_reg(2'd0, 16'h0000);
    set_evt(6'h01);
    chk_irq(1'b0, "R6 disabled");
    set_evt(6'h00);
    rd_reg(2'd1, 16'h0000, "R6 no pending");

    // R12 quick view
    wr_reg(2'd0, 16'h0002);
    set_evt(6'h20);
    rd_reg(2'd2, 16'h0080, "R12 quick view");
    rd_reg(2'd2, 16'h0080, "R12 not cleared");
    chk_irq(1'b1, "R12 irq held");
    rd_reg(2'd1, 16'h8000, "R9 clear read");
    set_evt(6'h00);

    // R10 event during clearing read
    rd_reg(2'd1, 16'h0000, "R10 idle");
    set_evt(6'h01);
    set_evt(6'h00);
    rd_reg(2'd1, 16'h8000, "R10 pending before");
    chk_irq(1'b0, "R10 cleared");
    rd_with_evt(2'd1, 6'h01, 16'h0000, "R10 coincident read");
    rd_reg(2'd1, 16'h8000, "R10 set wins");
    rd_reg(2'd1, 16'h0000, "R10 clears afterwards");
    set_evt(6'h00);

    // R11 test with enable off
    wr_reg(2'd0, 16'h0001);
    rd_reg(2'd0, 16'h0001, "R11 ctrl test only");
    chk_irq(1'b1, "R11 irq from test read");
    wr_reg(2'd0, 16'h0000);
    rd_reg(2'd1, 16'h8000, "R11 pending");
    rd_reg(2'd1, 16'h0000, "R11 cleared");
    chk_irq(1'b0, "R8 irq low");

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule